// File: doc/BRIEF.md
# PCI Type 0 Configuration Register File

This block is the configuration register file of a single-function PCI endpoint. The host side issues 32-bit configuration reads and writes. Each access selects one dword of the 256-byte space through a 6-bit index. The block implements the 64-byte common header: identity, command and status, up to six base address registers, the capability pointer and the interrupt line and pin. It also holds a short capability list in the device-specific region, with one header dword and one writable body dword per entry.

Identity values, BAR sizes and types, and the capability IDs are parameters. Device logic reports error events through a per-bit set input, and the pending interrupt level through a single input. A read returns its data on the clock edge after the read strobe, and the data stays on the output until the next read. A BAR that has been written with all ones returns its size mask, so software can size the region.

Top module: `pcicfg_target`

## Requirements
- R1: After reset, the command register, the sticky status bits, every BAR base, every capability body, cache line size, latency timer, interrupt line and the read data output are all zero.
- R2: Dword 0 reads {device ID, vendor ID}, dword 2 reads {class code, revision}, and dword 3 bits 23:16 read the header type. Writes to these fields have no effect.
- R3: `cfg_rdata` takes the addressed value on the edge that samples `cfg_rd` high, and otherwise holds its value. Dwords with no register read zero.
- R4: The command register occupies dword 1 bits 15:0. Only bits set in `CMD_WMASK` can be written, and all other command bits read zero.
- R5: The status register occupies dword 1 bits 31:16. Writing one to status bit 15, 14, 13, 12, 11 or 8 clears that bit, and writing zero leaves it unchanged. Bits 10:9 read `DEVSEL`, bit 4 reads one when capabilities exist, bit 3 follows `irq_pend`, and all other status bits read zero.
- R6: `stat_evt[0..5]` sets status bit 8, 11, 12, 13, 14 or 15 respectively. When a set and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R7: A memory BAR reads bit 0 as 0, bits 2:1 as 00 and bit 3 as its prefetch flag. Address bits below its size read zero.
- R8: An I/O BAR reads bit 0 as 1 and bit 1 as 0. Address bits below its size read zero. Disabled BAR slots (dwords 4..9) read zero.
- R9: After all ones is written to a BAR, the BAR reads back ~(size-1) combined with its fixed type bits.
- R10: Dword 13 bits 7:0 hold the offset of the first capability, with bits 1:0 zero. Each capability header carries its ID in bits 7:0 and the next offset in bits 15:8, and the last entry's next offset is 0x00. The first entry has ID 0x05.
- R11: Capability headers are read-only. The dword after each header is fully read/write.
- R12: Dword 3 bits 7:0 (cache line) and 15:8 (latency timer) and dword 15 bits 7:0 (interrupt line) are read/write. Dword 15 bits 15:8 read the `INT_PIN` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_idx | input | 6 | Dword index of the access |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_rd | input | 1 | Read strobe, one cycle per read |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| stat_evt | input | 6 | Per-bit set requests for the sticky status bits |
| irq_pend | input | 1 | Pending interrupt level shown in status bit 3 |

## Verification
The assertions assume that `stat_evt`, `cfg_wr`, `cfg_rd` and `cfg_idx` are synchronous, have known values and change only between clock edges. They do not assume that reads and writes are exclusive, but the bench still issues one strobe per access. The bench changes all of these inputs on the falling edge. It spreads random indices over the implemented dwords and the empty ones, and sometimes drives a status event together with a write that clears the same bit. It also writes all ones to each BAR and writes to the read-only dwords, so the sizing and masking corners appear under the same stimulus.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

   localparam int IDX_W       = 6;
   localparam int BAR_SLOTS   = 6;
   localparam int STICKY_BITS = 6;
   localparam int MAX_CAPS    = 8;

   localparam logic [IDX_W-1:0] DW_IDENT   = 6'd0;
   localparam logic [IDX_W-1:0] DW_CMDSTAT = 6'd1;
   localparam logic [IDX_W-1:0] DW_CLASS   = 6'd2;
   localparam logic [IDX_W-1:0] DW_MISC    = 6'd3;
   localparam logic [IDX_W-1:0] DW_BAR0    = 6'd4;
   localparam logic [IDX_W-1:0] DW_CAPPTR  = 6'd13;
   localparam logic [IDX_W-1:0] DW_INTR    = 6'd15;

   // status bit position driven by sticky slot k
   function automatic int sticky_pos(input int k);
      case (k)
         0: return 8;
         1: return 11;
         2: return 12;
         3: return 13;
         4: return 14;
         default: return 15;
      endcase
   endfunction

endpackage

// File: rtl/pcicfg_status.sv
module pcicfg_status
   import pcicfg_pkg::*;
#(
   parameter bit         CAP_PRESENT = 1'b1,
   parameter logic [1:0] DEVSEL      = 2'b01,
   parameter bit         FAST_B2B    = 1'b0,
   parameter bit         MHZ66       = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [15:0]            wr_bits,
   input  logic [STICKY_BITS-1:0] evt,
   input  logic                   irq_pend,
   output logic [15:0]            status
);

   logic [STICKY_BITS-1:0] sticky_q;
   logic                   unused_wbits;

   assign unused_wbits = ^{wr_bits[10:9], wr_bits[7:0]};

   for (genvar k = 0; k < STICKY_BITS; k++) begin : g_sticky
      localparam int POS = sticky_pos(k);

      always_ff @(posedge clk) begin
         if (!rst_n)
            sticky_q[k] <= 1'b0;
         else if (evt[k])
            sticky_q[k] <= 1'b1;
         else if (wr_en && wr_bits[POS])
            sticky_q[k] <= 1'b0;
      end

      assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
         evt[k] |=> status[POS]);
      assert_w1c_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_bits[POS] && !evt[k]) |=> !status[POS]);
      assert_w1c_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (!evt[k] && !(wr_en && wr_bits[POS])) |=> status[POS] == $past(status[POS]));
   end

   always_comb begin
      status      = '0;
      status[10:9] = DEVSEL;
      status[7]   = FAST_B2B;
      status[5]   = MHZ66;
      status[4]   = CAP_PRESENT;
      status[3]   = irq_pend;
      for (int k = 0; k < STICKY_BITS; k++)
         status[sticky_pos(k)] = sticky_q[k];
   end

endmodule

// File: rtl/pcicfg_bar.sv
module pcicfg_bar #(
   parameter bit IS_IO    = 1'b0,
   parameter bit PREFETCH = 1'b0,
   parameter int SZ_LOG2  = 12
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   output logic [31:0] value
);

   localparam int LOW_MIN = IS_IO ? 2 : 4;

   if (SZ_LOG2 < LOW_MIN || SZ_LOG2 > 31) begin : g_bad_size
      $error("pcicfg_bar: SZ_LOG2 outside the range allowed for this BAR type");
   end

   logic [31:SZ_LOG2] base_q;
   logic [3:0]        type_bits;
   logic              unused_low;

   assign unused_low = ^wdata[SZ_LOG2-1:0];

   if (IS_IO) begin : g_io
      assign type_bits = 4'b0001;
   end else begin : g_mem
      assign type_bits = {PREFETCH, 3'b000};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         base_q <= '0;
      else if (wr_en)
         base_q <= wdata[31:SZ_LOG2];
   end

   always_comb begin
      value              = '0;
      value[31:SZ_LOG2]  = base_q;
      value[3:0]         = value[3:0] | type_bits;
   end

   assert_probe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> value[31:SZ_LOG2] == $past(wdata[31:SZ_LOG2]));
   assert_bar_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(value));

endmodule

// File: rtl/pcicfg_caplist.sv
module pcicfg_caplist
   import pcicfg_pkg::*;
#(
   parameter int                    NUM_CAPS   = 2,
   parameter logic [7:0]            CAP_BASE   = 8'h40,
   parameter logic [7:0]            CAP_STRIDE = 8'h08,
   parameter logic [MAX_CAPS*8-1:0] CAP_IDS    = 64'h0905
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [31:0]      wdata,
   output logic             hit,
   output logic [31:0]      rd_val,
   output logic [7:0]       first_ptr
);

   localparam int BASE_DW   = int'(CAP_BASE) / 4;
   localparam int STRIDE_DW = int'(CAP_STRIDE) / 4;

   if (NUM_CAPS < 0 || NUM_CAPS > MAX_CAPS) begin : g_bad_count
      $error("pcicfg_caplist: NUM_CAPS out of range");
   end
   if (NUM_CAPS > 0 && (CAP_BASE < 8'h40 || CAP_BASE[1:0] != 2'b00 ||
       CAP_STRIDE < 8'h08 || CAP_STRIDE[1:0] != 2'b00 ||
       int'(CAP_BASE) + NUM_CAPS * int'(CAP_STRIDE) > 256)) begin : g_bad_layout
      $error("pcicfg_caplist: capability layout does not fit the device region");
   end

   if (NUM_CAPS == 0) begin : g_none
      logic unused_in;
      assign unused_in = ^{clk, rst_n, wr_en, idx, wdata};
      assign hit       = 1'b0;
      assign rd_val    = '0;
      assign first_ptr = 8'h00;
   end else begin : g_list
      logic        ent_hit [NUM_CAPS];
      logic [31:0] ent_val [NUM_CAPS];

      assign first_ptr = {CAP_BASE[7:2], 2'b00};

      for (genvar k = 0; k < NUM_CAPS; k++) begin : g_ent
         localparam logic [IDX_W-1:0] HDR_DW  = IDX_W'(BASE_DW + k * STRIDE_DW);
         localparam logic [IDX_W-1:0] BODY_DW = IDX_W'(BASE_DW + k * STRIDE_DW + 1);
         localparam logic [7:0]       NEXT    = (k == NUM_CAPS - 1) ? 8'h00 :
                                                8'(int'(CAP_BASE) + (k + 1) * int'(CAP_STRIDE));
         localparam logic [7:0]       ID      = CAP_IDS[k*8 +: 8];

         logic [31:0] body_q;

         always_ff @(posedge clk) begin
            if (!rst_n)
               body_q <= '0;
            else if (wr_en && idx == BODY_DW)
               body_q <= wdata;
         end

         assign ent_hit[k] = (idx == HDR_DW) || (idx == BODY_DW);
         assign ent_val[k] = (idx == HDR_DW)  ? {16'h0000, NEXT[7:2], 2'b00, ID} :
                             (idx == BODY_DW) ? body_q : 32'h0;

         assert_body_rw_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && idx == BODY_DW) |=> body_q == $past(wdata));
      end

      always_comb begin
         hit    = 1'b0;
         rd_val = '0;
         for (int k = 0; k < NUM_CAPS; k++) begin
            hit    = hit | ent_hit[k];
            rd_val = rd_val | ent_val[k];
         end
      end
   end

endmodule

// File: rtl/pcicfg_target.sv
module pcicfg_target
   import pcicfg_pkg::*;
#(
   parameter logic [15:0]           VENDOR_ID   = 16'h1D0C,
   parameter logic [15:0]           DEVICE_ID   = 16'h5A31,
   parameter logic [7:0]            REVISION    = 8'h02,
   parameter logic [23:0]           CLASS_CODE  = 24'h018000,
   parameter logic [7:0]            HEADER_TYPE = 8'h00,
   parameter logic [7:0]            INT_PIN     = 8'h01,
   parameter logic [15:0]           CMD_WMASK   = 16'h0547,
   parameter logic [1:0]            DEVSEL      = 2'b01,
   parameter logic [BAR_SLOTS-1:0]  BAR_EN      = 6'b000111,
   parameter logic [BAR_SLOTS-1:0]  BAR_IO      = 6'b000010,
   parameter logic [BAR_SLOTS-1:0]  BAR_PF      = 6'b000100,
   parameter logic [BAR_SLOTS*5-1:0] BAR_SZ     = {5'd4, 5'd4, 5'd4, 5'd20, 5'd5, 5'd12},
   parameter int                    NUM_CAPS    = 2,
   parameter logic [7:0]            CAP_BASE    = 8'h40,
   parameter logic [7:0]            CAP_STRIDE  = 8'h08,
   parameter logic [MAX_CAPS*8-1:0] CAP_IDS     = 64'h0905
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [IDX_W-1:0]       cfg_idx,
   input  logic                   cfg_wr,
   input  logic                   cfg_rd,
   input  logic [31:0]            cfg_wdata,
   output logic [31:0]            cfg_rdata,
   input  logic [STICKY_BITS-1:0] stat_evt,
   input  logic                   irq_pend
);

   if (CMD_WMASK[15:11] != 5'b0) begin : g_bad_cmd
      $error("pcicfg_target: CMD_WMASK reaches reserved command bits");
   end

   logic [15:0] cmd_q;
   logic [7:0]  cline_q, lat_q, int_line_q;
   logic [15:0] status_w;
   logic [31:0] bar_val [BAR_SLOTS];
   logic        cap_hit;
   logic [31:0] cap_val;
   logic [7:0]  cap_first;
   logic [31:0] rd_mux;
   logic [2:0]  bar_sel;

   // ---------------- command and misc header registers ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q      <= '0;
         cline_q    <= '0;
         lat_q      <= '0;
         int_line_q <= '0;
      end else if (cfg_wr) begin
         if (cfg_idx == DW_CMDSTAT) cmd_q <= cfg_wdata[15:0] & CMD_WMASK;
         if (cfg_idx == DW_MISC) begin
            cline_q <= cfg_wdata[7:0];
            lat_q   <= cfg_wdata[15:8];
         end
         if (cfg_idx == DW_INTR) int_line_q <= cfg_wdata[7:0];
      end
   end

   // ---------------- status ----------------
   pcicfg_status #(
      .CAP_PRESENT(NUM_CAPS > 0),
      .DEVSEL     (DEVSEL),
      .FAST_B2B   (1'b0),
      .MHZ66      (1'b0)
   ) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr && cfg_idx == DW_CMDSTAT),
      .wr_bits (cfg_wdata[31:16]),
      .evt     (stat_evt),
      .irq_pend(irq_pend),
      .status  (status_w)
   );

   // ---------------- base address registers ----------------
   for (genvar i = 0; i < BAR_SLOTS; i++) begin : g_bar
      localparam logic [IDX_W-1:0] MY_DW = DW_BAR0 + IDX_W'(i);
      if (BAR_EN[i]) begin : g_on
         localparam int         LOW  = BAR_IO[i] ? 2 : 4;
         localparam logic [3:0] TYPE = BAR_IO[i] ? 4'b0001 : {BAR_PF[i], 3'b000};

         pcicfg_bar #(
            .IS_IO   (BAR_IO[i]),
            .PREFETCH(BAR_PF[i]),
            .SZ_LOG2 (int'(BAR_SZ[i*5 +: 5]))
         ) u_bar (
            .clk  (clk),
            .rst_n(rst_n),
            .wr_en(cfg_wr && cfg_idx == MY_DW),
            .wdata(cfg_wdata),
            .value(bar_val[i])
         );

         assert_bar_type_R7_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_rd && cfg_idx == MY_DW) |=> cfg_rdata[LOW-1:0] == TYPE[LOW-1:0]);
      end else begin : g_off
         assign bar_val[i] = '0;
      end
   end

   // ---------------- capability list ----------------
   pcicfg_caplist #(
      .NUM_CAPS  (NUM_CAPS),
      .CAP_BASE  (CAP_BASE),
      .CAP_STRIDE(CAP_STRIDE),
      .CAP_IDS   (CAP_IDS)
   ) u_caps (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr),
      .idx      (cfg_idx),
      .wdata    (cfg_wdata),
      .hit      (cap_hit),
      .rd_val   (cap_val),
      .first_ptr(cap_first)
   );

   // ---------------- read path ----------------
   assign bar_sel = 3'(cfg_idx - DW_BAR0);

   always_comb begin
      rd_mux = '0;
      case (cfg_idx)
         DW_IDENT:   rd_mux = {DEVICE_ID, VENDOR_ID};
         DW_CMDSTAT: rd_mux = {status_w, cmd_q};
         DW_CLASS:   rd_mux = {CLASS_CODE, REVISION};
         DW_MISC:    rd_mux = {8'h00, HEADER_TYPE, lat_q, cline_q};
         DW_CAPPTR:  rd_mux = {24'h0, cap_first};
         DW_INTR:    rd_mux = {16'h0, INT_PIN, int_line_q};
         default: begin
            if (cfg_idx >= DW_BAR0 && cfg_idx < DW_BAR0 + 6'(BAR_SLOTS))
               rd_mux = bar_val[bar_sel];
            else if (cap_hit)
               rd_mux = cap_val;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cfg_rdata <= '0;
      else if (cfg_rd)
         cfg_rdata <= rd_mux;
   end

   assert_ident_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && cfg_idx == DW_IDENT) |=> cfg_rdata == {DEVICE_ID, VENDOR_ID});
   assert_cmd_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && cfg_idx == DW_CMDSTAT) |=> (cfg_rdata[15:0] & ~CMD_WMASK) == 16'h0);
   assert_capptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && cfg_idx == DW_CAPPTR) |=> (cfg_rdata[1:0] == 2'b00 && cfg_rdata[31:8] == 24'h0));
   assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rd |=> $stable(cfg_rdata));

endmodule

// File: tb/pcicfg_target_bench.sv
`timescale 1ns/1ps
module pcicfg_target_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  cfg_idx = '0;
   logic        cfg_wr = 1'b0;
   logic        cfg_rd = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [5:0]  stat_evt = '0;
   logic        irq_pend = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   pcicfg_target u_pcicfg_target (
      .clk(clk), .rst_n(rst_n), .cfg_idx(cfg_idx), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .stat_evt(stat_evt), .irq_pend(irq_pend)
   );

   // ---------------- reference state ----------------
   logic [15:0] m_cmd;
   logic [5:0]  m_sticky;
   logic [31:0] m_bar [3];
   logic [31:0] m_body [2];
   logic [7:0]  m_cl, m_lat, m_il;

   function automatic logic [31:0] bar_expect(int i);
      case (i)
         0: return (m_bar[0] & 32'hFFFF_F000);
         1: return (m_bar[1] & 32'hFFFF_FFE0) | 32'h1;
         default: return (m_bar[2] & 32'hFFF0_0000) | 32'h8;
      endcase
   endfunction

   function automatic logic [31:0] expect_rd(logic [5:0] idx);
      logic [15:0] st;
      st = {m_sticky[5:1], 2'b01, m_sticky[0], 3'b000, 1'b1, irq_pend, 3'b000};
      case (idx)
         6'd0:  return {16'h5A31, 16'h1D0C};
         6'd1:  return {st, m_cmd};
         6'd2:  return {24'h018000, 8'h02};
         6'd3:  return {16'h0000, m_lat, m_cl};
         6'd4:  return bar_expect(0);
         6'd5:  return bar_expect(1);
         6'd6:  return bar_expect(2);
         6'd13: return 32'h0000_0040;
         6'd15: return {16'h0000, 8'h01, m_il};
         6'd16: return 32'h0000_4805;
         6'd17: return m_body[0];
         6'd18: return 32'h0000_0009;
         6'd19: return m_body[1];
         default: return 32'h0;
      endcase
   endfunction

   task automatic model_reset();
      m_cmd = '0; m_sticky = '0; m_cl = '0; m_lat = '0; m_il = '0;
      for (int i = 0; i < 3; i++) m_bar[i] = '0;
      for (int i = 0; i < 2; i++) m_body[i] = '0;
   endtask

   task automatic model_step(bit wr, logic [5:0] idx, logic [31:0] d, logic [5:0] ev);
      int pos [6] = '{24, 27, 28, 29, 30, 31};
      for (int k = 0; k < 6; k++) begin
         if (ev[k]) m_sticky[k] = 1'b1;
         else if (wr && idx == 6'd1 && d[pos[k]]) m_sticky[k] = 1'b0;
      end
      if (wr) begin
         case (idx)
            6'd1:  m_cmd = d[15:0] & 16'h0547;
            6'd3:  begin m_cl = d[7:0]; m_lat = d[15:8]; end
            6'd4:  m_bar[0] = d;
            6'd5:  m_bar[1] = d;
            6'd6:  m_bar[2] = d;
            6'd15: m_il = d[7:0];
            6'd17: m_body[0] = d;
            6'd19: m_body[1] = d;
            default: ;
         endcase
      end
   endtask

   // ---------------- access tasks ----------------
   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   task automatic cycle(bit wr, logic [5:0] idx, logic [31:0] d, logic [5:0] ev);
      @(negedge clk);
      cfg_wr = wr; cfg_idx = idx; cfg_wdata = d; stat_evt = ev;
      @(negedge clk);
      cfg_wr = 1'b0; stat_evt = '0;
      model_step(wr, idx, d, ev);
   endtask

   task automatic rd_check(logic [5:0] idx, string tag);
      logic [31:0] exp;
      @(negedge clk);
      cfg_rd = 1'b1; cfg_idx = idx;
      exp = expect_rd(idx);
      @(negedge clk);
      cfg_rd = 1'b0;
      check(tag, cfg_rdata, exp);
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin : main
      logic [31:0] held;
      void'($urandom(32'd7));
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 rdata after reset", cfg_rdata, 32'h0);
      rd_check(6'd1, "R1 cmd/status reset");
      rd_check(6'd4, "R1 BAR0 reset");
      rd_check(6'd17, "R1 cap body reset");
      rd_check(6'd3, "R1 misc reset");

      // R2 read-only identity
      cycle(1'b1, 6'd0, 32'hFFFF_FFFF, 6'h0);
      rd_check(6'd0, "R2 ident after write");
      cycle(1'b1, 6'd2, 32'h0, 6'h0);
      rd_check(6'd2, "R2 class after write");

      // R4 command mask
      cycle(1'b1, 6'd1, 32'h0000_FFFF, 6'h0);
      rd_check(6'd1, "R4 command mask");

      // R6 set then R5 selective clear
      cycle(1'b0, 6'd0, 32'h0, 6'h3F);
      rd_check(6'd1, "R6 all sticky set");
      cycle(1'b1, 6'd1, 32'h0900_0000, 6'h0);
      rd_check(6'd1, "R5 clear bits 8 and 11");
      cycle(1'b1, 6'd1, 32'h0000_0000, 6'h0);
      rd_check(6'd1, "R5 write zero keeps");
      cycle(1'b1, 6'd1, 32'hF900_0000, 6'h20);
      rd_check(6'd1, "R6 set beats clear");
      irq_pend = 1'b1;
      rd_check(6'd1, "R5 irq status bit");
      irq_pend = 1'b0;

      // R7 R8 R9 BAR encoding and probing
      cycle(1'b1, 6'd4, 32'hFFFF_FFFF, 6'h0);
      rd_check(6'd4, "R9 R7 BAR0 size mask");
      cycle(1'b1, 6'd5, 32'hFFFF_FFFF, 6'h0);
      rd_check(6'd5, "R9 R8 BAR1 io size mask");
      cycle(1'b1, 6'd6, 32'hFFFF_FFFF, 6'h0);
      rd_check(6'd6, "R9 R7 BAR2 prefetch mask");
      cycle(1'b1, 6'd4, 32'h1234_5678, 6'h0);
      rd_check(6'd4, "R7 BAR0 low bits zero");
      cycle(1'b1, 6'd7, 32'hFFFF_FFFF, 6'h0);
      rd_check(6'd7, "R8 disabled BAR slot");

      // R10 R11 capability chain
      rd_check(6'd13, "R10 capability pointer");
      rd_check(6'd16, "R10 first cap MSI");
      rd_check(6'd18, "R10 last cap terminates");
      cycle(1'b1, 6'd16, 32'hFFFF_FFFF, 6'h0);
      rd_check(6'd16, "R11 header read-only");
      cycle(1'b1, 6'd19, 32'hCAFE_0123, 6'h0);
      rd_check(6'd19, "R11 body read/write");

      // R12 misc registers
      cycle(1'b1, 6'd3, 32'hFFFF_A55A, 6'h0);
      rd_check(6'd3, "R12 cache line and latency");
      cycle(1'b1, 6'd15, 32'hFFFF_FF3C, 6'h0);
      rd_check(6'd15, "R12 interrupt line and pin");

      // R3 hold and empty dword
      rd_check(6'd0, "R3 read ident");
      held = cfg_rdata;
      cycle(1'b1, 6'd1, 32'h0000_0001, 6'h0);
      check("R3 rdata holds without read", cfg_rdata, held);
      cycle(1'b1, 6'd40, 32'hFFFF_FFFF, 6'h0);
      rd_check(6'd40, "R3 empty dword reads zero");

      // constrained random mix
      for (int it = 0; it < 1500; it++) begin
         int op;
         logic [5:0]  idx;
         logic [31:0] d;
         logic [5:0]  ev;
         op  = int'($urandom % 8);
         idx = ($urandom % 4 == 0) ? 6'($urandom) : 6'($urandom % 21);
         d   = ($urandom % 6 == 0) ? 32'hFFFF_FFFF : $urandom;
         ev  = ($urandom % 3 == 0) ? 6'($urandom) : 6'h0;
         irq_pend = ($urandom % 5 == 0);
         if (op < 3)       cycle(1'b1, idx, d, ev);
         else if (op == 3) cycle(1'b0, idx, d, ev);
         else              rd_check(idx, "R5 R7 R9 R11 random read");
      end

      done = 1'b1;
      report();
   end

endmodule